// File: doc/BRIEF.md
# SIMD Pixel-Line Processor Array

This block is a row of identical processing elements (PEs). Every PE executes the same broadcast instruction in the same clock cycle on its own data. Each PE owns one column of an image line and keeps it in a private byte-wide local memory, so one instruction touches a whole pixel line at once rather than walking the line pixel by pixel.

Each PE contains four parts:
- a bank of 8-bit general registers;
- a one-bit condition flag;
- a small ALU, whose multiply and multiply-accumulate results are 16 bits wide and go to a register pair;
- a link to its two neighbours, whose register values it can read as an operand in the same cycle.

Every instruction completes in one cycle. A host port moves a full line into or out of the local memories of all PEs while no instruction is being issued. The block raises `busy` for the one cycle in which that transfer is carried out.

Top module: `simd_line_array`

## Requirements
- R1: After reset `busy`, `done` and `hostRdValid` are 0, and every register of every PE reads as zero.
- R2: A host request (`hostWe` or `hostRe`, write taking priority) presented while `instrValid` and `busy` are both low is accepted at that clock edge. `busy` is then high for exactly the next cycle, during which the transfer runs. A read returns memory byte `hostAddr` of PE i in `hostRdLine[8*i+7:8*i]`, with `hostRdValid` high in the cycle after `busy`. A write stores `hostWrLine[8*i+7:8*i]` into PE i.
- R3: `instrWord` is laid out as op[29:26], rd[25:21], ra[20:16], rb[15:11], nsel[10:9], maskEn[8], imm[7:0]. The 8-bit wrapping operations are: ADD=1 (a+b), SUB=2 (a-b), AND=3, OR=4, XOR=5, ADDI=6 (a+imm), MOVI=7 (imm), and SHR=14 (a>>imm[2:0]). Here a is register ra and b is the selected b operand. Opcodes 0 and 15 do nothing.
- R4: MUL=8 writes the 16-bit product a*b to the register pair, low byte in rd and high byte in rd+1. MAC=9 adds a*b to the 16-bit value held in {rd+1, rd}, wrapping at 16 bits.
- R5: nsel picks the b operand. 0 or 3 selects register rb of the PE itself. 1 selects register rb of PE i-1, and 2 selects register rb of PE i+1. A neighbour beyond either end of the row reads as zero.
- R6: CMPLT=10 sets the flag to (a<b) unsigned, and CMPEQ=11 sets it to (a==b). When maskEn=1, an instruction changes registers, flag and memory only in PEs whose flag is 1.
- R7: LDL=12 loads memory byte imm into rd, and STL=13 stores register ra into memory byte imm. Both take one cycle and move one byte in every PE.
- R8: An instruction presented while `busy` is high is dropped with no effect. A host request presented together with `instrValid` is ignored, and the instruction executes.
- R9: `done` is high for one cycle after each executed instruction and after each host transfer cycle.
- R10: A register index of 28 or more reads as zero and is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Broadcast instruction strobe |
| instrWord | input | 30 | Broadcast instruction |
| hostWe | input | 1 | Host line write request |
| hostRe | input | 1 | Host line read request |
| hostAddr | input | LINE_AW | Host line index |
| hostWrLine | input | NUM_PE*8 | Line to write, PE i in byte i |
| hostRdLine | output | NUM_PE*8 | Line read back, PE i in byte i |
| hostRdValid | output | 1 | hostRdLine holds fresh data |
| busy | output | 1 | Host transfer in progress |
| done | output | 1 | Instruction or transfer completed |

## Verification
Two collisions are provoked on purpose, because an instruction and a host line transfer can meet in the same cycle.

In the first, `hostWe` and `instrValid` are raised on the same edge. The bench then checks two things: `busy` stays low, and the line later read from the target address still holds its old contents while the instruction's register result is present.

In the second, an instruction is presented during the one cycle in which `busy` is high. A later store of its destination register must return the register's reset value.

// File: rtl/simd_line_pkg.sv
package simd_line_pkg;
  localparam int DATA_W  = 8;
  localparam int RIDX_W  = 5;
  localparam int ADDR_W  = 8;
  localparam int INSTR_W = 30;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,  OP_ADD  = 4'd1,  OP_SUB   = 4'd2,  OP_AND   = 4'd3,
    OP_OR    = 4'd4,  OP_XOR  = 4'd5,  OP_ADDI  = 4'd6,  OP_MOVI  = 4'd7,
    OP_MUL   = 4'd8,  OP_MAC  = 4'd9,  OP_CMPLT = 4'd10, OP_CMPEQ = 4'd11,
    OP_LDL   = 4'd12, OP_STL  = 4'd13, OP_SHR   = 4'd14, OP_RSV   = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    NB_SELF = 2'd0, NB_LEFT = 2'd1, NB_RIGHT = 2'd2, NB_SELF2 = 2'd3
  } nbsel_e;

  typedef struct packed {
    opcode_e             op;
    logic [RIDX_W-1:0]   rd;
    logic [RIDX_W-1:0]   ra;
    logic [RIDX_W-1:0]   rb;
    nbsel_e              nsel;
    logic                maskEn;
    logic [DATA_W-1:0]   imm;
  } instr_t;

  typedef struct packed {
    logic              issue;
    instr_t            instr;
    logic              hostCapture;
    logic              hostWrite;
    logic              hostRead;
    logic [ADDR_W-1:0] hostAddr;
  } ctrl_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_line_pkg::*;
#(
  parameter int LINE_AW = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               hostWe,
  input  logic               hostRe,
  input  logic [LINE_AW-1:0] hostAddr,
  output ctrl_t              ctrlOut,
  output logic               busy,
  output logic               done,
  output logic               hostRdValid
);
  logic               issue;
  logic               acceptHost;
  logic               pendWr;
  logic [LINE_AW-1:0] pendAddr;

  always_comb begin
    issue      = instrValid && !busy;
    acceptHost = (hostWe || hostRe) && !instrValid && !busy;
    ctrlOut.issue       = issue;
    ctrlOut.instr       = instr_t'(instrWord);
    ctrlOut.hostCapture = acceptHost && hostWe;
    ctrlOut.hostWrite   = busy && pendWr;
    ctrlOut.hostRead    = busy && !pendWr;
    ctrlOut.hostAddr    = ADDR_W'(pendAddr);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy        <= 1'b0;
      pendWr      <= 1'b0;
      pendAddr    <= '0;
      done        <= 1'b0;
      hostRdValid <= 1'b0;
    end else begin
      busy        <= acceptHost;
      done        <= issue || busy;
      hostRdValid <= busy && !pendWr;
      if (acceptHost) begin
        pendWr   <= hostWe;
        pendAddr <= hostAddr;
      end
    end
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_line_pkg::*;
#(
  parameter int NUM_REG = 28,
  parameter int LINE_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] leftB,
  input  logic [DATA_W-1:0] rightB,
  input  logic [DATA_W-1:0] hostByte,
  output logic [DATA_W-1:0] ownB,
  output logic [DATA_W-1:0] rdByte
);
  localparam int MEM_DEPTH = 1 << LINE_AW;

  logic [DATA_W-1:0]   regs [NUM_REG];
  logic [DATA_W-1:0]   mem  [MEM_DEPTH];
  logic                flag;
  logic [DATA_W-1:0]   hostHold;

  logic [DATA_W-1:0]   aVal, bVal, loOld, hiOld, loVal, hiVal;
  logic [RIDX_W:0]     rdHi;
  logic [2*DATA_W-1:0] prod, acc;
  logic                enable, wrLo, wrHi, flagWr, flagVal, memWr;
  logic [LINE_AW-1:0]  immAddr, hostIdx;

  always_comb begin
    immAddr = ctrl.instr.imm[LINE_AW-1:0];
    hostIdx = ctrl.hostAddr[LINE_AW-1:0];
    rdHi    = {1'b0, ctrl.instr.rd} + 1'b1;
    aVal    = (32'(ctrl.instr.ra) < NUM_REG) ? regs[ctrl.instr.ra] : '0;
    ownB    = (32'(ctrl.instr.rb) < NUM_REG) ? regs[ctrl.instr.rb] : '0;
    loOld   = (32'(ctrl.instr.rd) < NUM_REG) ? regs[ctrl.instr.rd] : '0;
    hiOld   = (32'(rdHi) < NUM_REG) ? regs[rdHi[RIDX_W-1:0]] : '0;
    case (ctrl.instr.nsel)
      NB_LEFT:  bVal = leftB;
      NB_RIGHT: bVal = rightB;
      default:  bVal = ownB;
    endcase
    prod = (2*DATA_W)'(aVal) * (2*DATA_W)'(bVal);
    acc  = {hiOld, loOld} + prod;
  end

  always_comb begin
    enable  = ctrl.issue && (!ctrl.instr.maskEn || flag);
    wrLo    = 1'b0;
    wrHi    = 1'b0;
    loVal   = '0;
    hiVal   = '0;
    flagWr  = 1'b0;
    flagVal = 1'b0;
    memWr   = 1'b0;
    if (enable) begin
      case (ctrl.instr.op)
        OP_ADD:   begin wrLo = 1'b1; loVal = aVal + bVal; end
        OP_SUB:   begin wrLo = 1'b1; loVal = aVal - bVal; end
        OP_AND:   begin wrLo = 1'b1; loVal = aVal & bVal; end
        OP_OR:    begin wrLo = 1'b1; loVal = aVal | bVal; end
        OP_XOR:   begin wrLo = 1'b1; loVal = aVal ^ bVal; end
        OP_ADDI:  begin wrLo = 1'b1; loVal = aVal + ctrl.instr.imm; end
        OP_MOVI:  begin wrLo = 1'b1; loVal = ctrl.instr.imm; end
        OP_SHR:   begin wrLo = 1'b1; loVal = aVal >> ctrl.instr.imm[2:0]; end
        OP_MUL:   begin wrLo = 1'b1; wrHi = 1'b1; {hiVal, loVal} = prod; end
        OP_MAC:   begin wrLo = 1'b1; wrHi = 1'b1; {hiVal, loVal} = acc; end
        OP_CMPLT: begin flagWr = 1'b1; flagVal = aVal < bVal; end
        OP_CMPEQ: begin flagWr = 1'b1; flagVal = aVal == bVal; end
        OP_LDL:   begin wrLo = 1'b1; loVal = mem[immAddr]; end
        OP_STL:   memWr = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_REG; k++) regs[k] <= '0;
      flag     <= 1'b0;
      hostHold <= '0;
      rdByte   <= '0;
    end else begin
      if (wrLo && (32'(ctrl.instr.rd) < NUM_REG)) regs[ctrl.instr.rd] <= loVal;
      if (wrHi && (32'(rdHi) < NUM_REG)) regs[rdHi[RIDX_W-1:0]] <= hiVal;
      if (flagWr) flag <= flagVal;
      if (ctrl.hostCapture) hostHold <= hostByte;
      if (ctrl.hostRead) rdByte <= mem[hostIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (memWr) mem[immAddr] <= aVal;
    else if (ctrl.hostWrite) mem[hostIdx] <= hostHold;
  end
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_line_pkg::*;
#(
  parameter int NUM_PE  = 8,
  parameter int NUM_REG = 28,
  parameter int LINE_AW = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrl_t                    ctrl,
  input  logic [NUM_PE*DATA_W-1:0] hostWrLine,
  output logic [NUM_PE*DATA_W-1:0] hostRdLine
);
  logic [DATA_W-1:0] ownB [NUM_PE];

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    logic [DATA_W-1:0] leftB, rightB, rdByte;
    if (i == 0) begin : g_ledge
      assign leftB = '0;
    end else begin : g_lin
      assign leftB = ownB[i-1];
    end
    if (i == NUM_PE-1) begin : g_redge
      assign rightB = '0;
    end else begin : g_rin
      assign rightB = ownB[i+1];
    end
    simd_pe #(.NUM_REG(NUM_REG), .LINE_AW(LINE_AW)) u_pe (
      .clk      (clk),
      .rstN     (rstN),
      .ctrl     (ctrl),
      .leftB    (leftB),
      .rightB   (rightB),
      .hostByte (hostWrLine[i*DATA_W +: DATA_W]),
      .ownB     (ownB[i]),
      .rdByte   (rdByte)
    );
    assign hostRdLine[i*DATA_W +: DATA_W] = rdByte;
  end
endmodule

// File: rtl/simd_line_array.sv
module simd_line_array
  import simd_line_pkg::*;
#(
  parameter int NUM_PE  = 8,
  parameter int NUM_REG = 28,
  parameter int LINE_AW = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     instrValid,
  input  logic [INSTR_W-1:0]       instrWord,
  input  logic                     hostWe,
  input  logic                     hostRe,
  input  logic [LINE_AW-1:0]       hostAddr,
  input  logic [NUM_PE*DATA_W-1:0] hostWrLine,
  output logic [NUM_PE*DATA_W-1:0] hostRdLine,
  output logic                     hostRdValid,
  output logic                     busy,
  output logic                     done
);
  ctrl_t ctrl;

  simd_ctrl #(.LINE_AW(LINE_AW)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .instrValid  (instrValid),
    .instrWord   (instrWord),
    .hostWe      (hostWe),
    .hostRe      (hostRe),
    .hostAddr    (hostAddr),
    .ctrlOut     (ctrl),
    .busy        (busy),
    .done        (done),
    .hostRdValid (hostRdValid)
  );

  simd_datapath #(.NUM_PE(NUM_PE), .NUM_REG(NUM_REG), .LINE_AW(LINE_AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .hostWrLine (hostWrLine),
    .hostRdLine (hostRdLine)
  );
endmodule

// File: rtl/simd_line_array_chk.sv
module simd_line_array_chk (
  input logic clk,
  input logic rstN,
  input logic instrValid,
  input logic hostWe,
  input logic hostRe,
  input logic busy,
  input logic done,
  input logic hostRdValid
);
  assert_busy_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  assert_busy_from_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostWe || hostRe) && !$past(instrValid));

  assert_rdvalid_after_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid |-> $past(busy));

  assert_instr_blocks_host_R8: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> !busy);

  assert_done_after_issue_R9: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !busy) |=> done);

  assert_done_after_transfer_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> done);

  assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy || instrValid));
endmodule

bind simd_line_array simd_line_array_chk u_chk (.*);

// File: tb/simd_line_array_tb.sv
module simd_line_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int LW = NP * 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instrValid = 1'b0;
  logic [29:0]   instrWord = '0;
  logic          hostWe = 1'b0;
  logic          hostRe = 1'b0;
  logic [7:0]    hostAddr = '0;
  logic [LW-1:0] hostWrLine = '0;
  logic [LW-1:0] hostRdLine;
  logic          hostRdValid, busy, done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [LW-1:0] expQ[$];
  string         tagQ[$];

  int p [NP];
  int q [NP];
  logic [7:0] e [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_line_array #(.NUM_PE(NP), .NUM_REG(28), .LINE_AW(8)) u_dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .hostWe(hostWe), .hostRe(hostRe), .hostAddr(hostAddr),
    .hostWrLine(hostWrLine), .hostRdLine(hostRdLine),
    .hostRdValid(hostRdValid), .busy(busy), .done(done)
  );

  function automatic logic [29:0] mk(int op, int rd, int ra, int rb, int ns, int m, int imm);
    return {4'(op), 5'(rd), 5'(ra), 5'(rb), 2'(ns), 1'(m), 8'(imm)};
  endfunction

  function automatic logic [LW-1:0] packLine();
    logic [LW-1:0] v;
    for (int i = 0; i < NP; i++) v[i*8 +: 8] = e[i];
    return v;
  endfunction

  task automatic check(string req, logic [LW-1:0] act, logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read lines when the design presents them
  always @(negedge clk) begin
    if (rstN && hostRdValid) begin
      if (expQ.size() == 0) check("R2 unexpected read data", LW'(1), LW'(0));
      else check(tagQ.pop_front(), hostRdLine, expQ.pop_front());
    end
  end

  task automatic runOp(logic [29:0] w);
    @(negedge clk);
    instrValid = 1'b1; instrWord = w;
    @(negedge clk);
    instrValid = 1'b0;
    check("R9 done after instruction", LW'(done), LW'(1));
  endtask

  task automatic hostWrite(int addr, logic [LW-1:0] line);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 8'(addr); hostWrLine = line;
    @(negedge clk);
    hostWe = 1'b0;
    check("R2 busy during write", LW'(busy), LW'(1));
    @(negedge clk);
    check("R2 busy single cycle", LW'(busy), LW'(0));
    check("R9 done after transfer", LW'(done), LW'(1));
  endtask

  task automatic hostRead(int addr, string tag);
    expQ.push_back(packLine());
    tagQ.push_back(tag);
    @(negedge clk);
    hostRe = 1'b1; hostAddr = 8'(addr);
    @(negedge clk);
    hostRe = 1'b0;
    check("R2 busy during read", LW'(busy), LW'(1));
    @(negedge clk);
  endtask

  task automatic storeRead(int reg_i, int addr, string tag);
    runOp(mk(13, 0, reg_i, 0, 0, 0, addr));
    hostRead(addr, tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      p[i] = 10 * i + 3;
      q[i] = 200 + 7 * i;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", LW'(busy), LW'(0));
    check("R1 done", LW'(done), LW'(0));
    check("R1 hostRdValid", LW'(hostRdValid), LW'(0));
    for (int i = 0; i < NP; i++) e[i] = 8'h00;
    storeRead(9, 5, "R1 register reset value");

    // R2: host line write/read
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i]);
    hostWrite(1, packLine());
    hostRead(1, "R2 line readback");
    for (int i = 0; i < NP; i++) e[i] = 8'(q[i]);
    hostWrite(2, packLine());

    // R7: line loads
    runOp(mk(12, 1, 0, 0, 0, 0, 1));
    runOp(mk(12, 2, 0, 0, 0, 0, 2));
    for (int i = 0; i < NP; i++) e[i] = 8'(q[i]);
    storeRead(2, 9, "R7 load then store");

    // R3: ALU
    runOp(mk(1, 3, 1, 2, 0, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i] + q[i]);
    storeRead(3, 10, "R3 ADD");
    runOp(mk(2, 4, 1, 2, 0, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i] - q[i]);
    storeRead(4, 11, "R3 SUB");
    runOp(mk(5, 5, 1, 2, 3, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i] ^ q[i]);
    storeRead(5, 12, "R3 XOR");
    runOp(mk(6, 6, 1, 0, 0, 0, 8'hF0));
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i] + 8'hF0);
    storeRead(6, 13, "R3 ADDI");
    runOp(mk(14, 7, 2, 0, 0, 0, 3));
    for (int i = 0; i < NP; i++) e[i] = 8'(q[i] >> 3);
    storeRead(7, 14, "R3 SHR");
    runOp(mk(3, 8, 1, 2, 0, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i] & q[i]);
    storeRead(8, 15, "R3 AND");

    // R4: multiply into pair, then accumulate
    runOp(mk(8, 10, 1, 2, 0, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i] * q[i]);
    storeRead(10, 20, "R4 MUL low");
    for (int i = 0; i < NP; i++) e[i] = 8'((p[i] * q[i]) >> 8);
    storeRead(11, 21, "R4 MUL high");
    runOp(mk(9, 10, 1, 1, 0, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = 8'((p[i] * q[i] + p[i] * p[i]) >> 8);
    storeRead(11, 22, "R4 MAC high");
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i] * q[i] + p[i] * p[i]);
    storeRead(10, 23, "R4 MAC low");

    // R5: neighbour operand, zero at edges
    runOp(mk(1, 12, 0, 1, 1, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = (i == 0) ? 8'h00 : 8'(p[i-1]);
    storeRead(12, 24, "R5 left neighbour");
    runOp(mk(1, 12, 0, 1, 2, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = (i == NP-1) ? 8'h00 : 8'(p[i+1]);
    storeRead(12, 25, "R5 right neighbour");

    // R6: compare and masked writes
    runOp(mk(7, 13, 0, 0, 0, 0, 40));
    runOp(mk(10, 0, 1, 13, 0, 0, 0));
    runOp(mk(7, 14, 0, 0, 0, 1, 8'h77));
    for (int i = 0; i < NP; i++) e[i] = (p[i] < 40) ? 8'h77 : 8'h00;
    storeRead(14, 26, "R6 masked MOVI after CMPLT");
    for (int i = 0; i < NP; i++) e[i] = 8'hEE;
    hostWrite(30, packLine());
    runOp(mk(13, 0, 1, 0, 0, 1, 30));
    for (int i = 0; i < NP; i++) e[i] = (p[i] < 40) ? 8'(p[i]) : 8'hEE;
    hostRead(30, "R6 masked store");
    runOp(mk(11, 0, 1, 1, 0, 0, 0));
    runOp(mk(7, 14, 0, 0, 0, 1, 8'h11));
    for (int i = 0; i < NP; i++) e[i] = 8'h11;
    storeRead(14, 27, "R6 CMPEQ sets all flags");

    // R8: collision of host request and instruction
    for (int i = 0; i < NP; i++) e[i] = 8'h33;
    hostWrite(40, packLine());
    @(negedge clk);
    instrValid = 1'b1; instrWord = mk(7, 15, 0, 0, 0, 0, 8'h44);
    hostWe = 1'b1; hostAddr = 8'd40; hostWrLine = {NP{8'h99}};
    @(negedge clk);
    instrValid = 1'b0; hostWe = 1'b0;
    check("R8 host ignored with instruction busy", LW'(busy), LW'(0));
    @(negedge clk);
    hostRead(40, "R8 ignored host write left line");
    for (int i = 0; i < NP; i++) e[i] = 8'h44;
    storeRead(15, 41, "R8 colliding instruction executed");
    // instruction during busy is dropped
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 8'd42; hostWrLine = {NP{8'h21}};
    @(negedge clk);
    hostWe = 1'b0;
    check("R8 busy for drop test", LW'(busy), LW'(1));
    instrValid = 1'b1; instrWord = mk(7, 16, 0, 0, 0, 0, 8'h55);
    @(negedge clk);
    instrValid = 1'b0;
    for (int i = 0; i < NP; i++) e[i] = 8'h00;
    storeRead(16, 43, "R8 instruction during busy dropped");
    for (int i = 0; i < NP; i++) e[i] = 8'h21;
    hostRead(42, "R8 transfer completed despite instruction");

    // R10: out-of-range register index
    runOp(mk(7, 30, 0, 0, 0, 0, 8'h66));
    runOp(mk(1, 17, 30, 1, 0, 0, 0));
    for (int i = 0; i < NP; i++) e[i] = 8'(p[i]);
    storeRead(17, 44, "R10 index 30 reads zero");

    repeat (3) @(negedge clk);
    check("R2 all reads returned", LW'(expQ.size()), LW'(0));
    finished = 1;
    finish_run();
  end
endmodule